// File: doc/BRIEF.md
# Raster Line and Frame Timing Generator

This block runs from the video master clock and keeps two raster counters: a horizontal tick position within the current line and a vertical line number within the current frame. Every other output is decoded from those two counters. The decoded outputs are a dot-clock enable, a picture-window flag, a vertical-blank flag, a processor stall window that reserves a slice of each line for memory refresh, a pulse at the start of each line and a pulse at the start of each frame. A frame-parity flag is also provided.

Static configuration pins select the frame length (60 Hz or 50 Hz line count), the picture height (224 or 239 lines) and interlace. Interlace adds one line to every even frame. A forced-blank pin turns the picture window off and leaves all timing untouched. The block has no data stream, so every pin is a plain level or pulse and none of them handshakes. All outputs are decoded combinationally from registered state, and they change only at master clock edges.

Top module: `raster_timing_gen`

## Requirements
- R1: `hpos` counts from 0 to LINE_TICKS-1 (default 1364) and then returns to 0. `line_start` is high exactly when `hpos` is 0.
- R2: `dot_en` is high on every DOT_DIV-th tick (default 4), starting at `hpos` 0, so it is high exactly when `hpos` is a multiple of DOT_DIV. This gives 341 dots per line by default.
- R3: `cpu_stall` is high exactly for `hpos` in [STALL_START, STALL_START+STALL_LEN), which is 536 to 575 by default. That is 40 consecutive ticks in every line.
- R4: `active` is high when all of the following hold: `hpos` is in [PIC_START, PIC_END) (88 to 1111 by default), `vpos` is in 1 to H, and `force_blank` is low. H is 224 when `cfg_tall` is 0 and 239 when it is 1. Line 0 is never active.
- R5: `vblank` is high when `vpos` is greater than H, from line 225 (or 240) through the last line of the frame. It is low on lines 0 to H.
- R6: `vpos` advances on the last tick of each line. The line on which it wraps to 0 is 261 when `cfg_50hz` is 0 and 311 when it is 1. Wrapping happens whenever `vpos` is at or beyond that line at the end of a line.
- R7: When `cfg_interlace` is 1 and `even_frame` is 1, the wrap line is one later (262 or 312), so the frame has one extra line.
- R8: Reset gives `hpos`=0, `vpos`=0 and `even_frame`=1. `even_frame` inverts at every frame wrap.
- R9: `frame_start` is high exactly when `hpos` and `vpos` are both 0.
- R10: `force_blank` only clears `active`. `hpos`, `vpos`, `vblank`, `cpu_stall` and `dot_en` are the same as they would be with `force_blank` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_50hz | input | 1 | 1 selects the 50 Hz frame length |
| cfg_tall | input | 1 | 1 selects the 239-line picture height |
| cfg_interlace | input | 1 | 1 adds a line to even frames |
| force_blank | input | 1 | Clears the picture window |
| hpos | output | $clog2(LINE_TICKS) | Tick position within the line |
| vpos | output | $clog2(LAST_LINE_50+2) | Line number within the frame |
| dot_en | output | 1 | Dot-clock enable |
| line_start | output | 1 | High on tick 0 of each line |
| active | output | 1 | Picture window |
| vblank | output | 1 | Vertical blanking |
| cpu_stall | output | 1 | Processor stall for refresh |
| frame_start | output | 1 | High on tick 0 of line 0 |
| even_frame | output | 1 | Frame parity, 1 on even frames |

## Verification
The embedded assertions check the following on every cycle: the horizontal range and wrap, dot alignment at line start, the exact length of each stall run, the parity flip at each frame wrap, the upper bound on `vpos`, and the exclusions that keep `active` off during forced blank, vertical blank and line 0. Some behaviour depends on configuration and only the bench scenarios can show it: the frame length for each rate, the extra interlace line falling on even frames only, and blanking moving with the picture height. The bench shows these by comparing every output against an independent model across frames in every mode, using a shortened line so that whole frames fit in the run.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // True when v lies in the half-open span [lo, hi).
  function automatic logic in_span(input int unsigned v, input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v < hi);
  endfunction
endpackage

// File: rtl/rtg_hcount.sv
module rtg_hcount #(
  parameter int unsigned LINE_TICKS = 1364,
  parameter int unsigned DOT_DIV    = 4,
  parameter int unsigned HW         = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hpos,
  output logic          line_end,
  output logic          dot_en
);
  logic [HW-1:0] hpos_q;

  assign hpos     = hpos_q;
  assign line_end = (hpos_q == HW'(LINE_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        hpos_q <= '0;
    else if (line_end) hpos_q <= '0;
    else               hpos_q <= hpos_q + 1'b1;
  end

  generate
    if (DOT_DIV > 1) begin : g_div
      localparam int unsigned PW = $clog2(DOT_DIV);
      logic [PW-1:0] phase_q;
      always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else if (line_end || phase_q == PW'(DOT_DIV - 1)) phase_q <= '0;
        else phase_q <= phase_q + 1'b1;
      end
      assign dot_en = (phase_q == '0);
    end else begin : g_nodiv
      assign dot_en = 1'b1;
    end
  endgenerate

  p_hpos_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hpos_q < HW'(LINE_TICKS));
  p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> hpos_q == '0);
  p_dot_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos_q == '0) |-> dot_en);
endmodule

// File: rtl/rtg_vcount.sv
module rtg_vcount #(
  parameter int unsigned LAST_LINE_60 = 261,
  parameter int unsigned LAST_LINE_50 = 311,
  parameter int unsigned VW           = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic          cfg_50hz,
  input  logic          cfg_interlace,
  output logic [VW-1:0] vpos,
  output logic          even_frame
);
  logic [VW-1:0] vpos_q;
  logic          even_q;
  logic [VW-1:0] wrap_line;
  logic          frame_wrap;

  assign wrap_line  = (cfg_50hz ? VW'(LAST_LINE_50) : VW'(LAST_LINE_60))
                    + VW'(cfg_interlace & even_q);
  assign frame_wrap = line_end && (vpos_q >= wrap_line);
  assign vpos       = vpos_q;
  assign even_frame = even_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpos_q <= '0;
      even_q <= 1'b1;
    end else if (frame_wrap) begin
      vpos_q <= '0;
      even_q <= ~even_q;
    end else if (line_end) begin
      vpos_q <= vpos_q + 1'b1;
    end
  end

  p_vpos_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vpos_q));
  p_vpos_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vpos_q <= VW'(LAST_LINE_50 + 1));
  p_parity_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (even_q != $past(even_q)) && (vpos_q == '0));
endmodule

// File: rtl/rtg_window.sv
module rtg_window
  import rtg_pkg::*;
#(
  parameter int unsigned PIC_START    = 88,
  parameter int unsigned PIC_END      = 1112,
  parameter int unsigned STALL_START  = 536,
  parameter int unsigned STALL_LEN    = 40,
  parameter int unsigned SHORT_HEIGHT = 224,
  parameter int unsigned TALL_HEIGHT  = 239,
  parameter int unsigned HW           = 11,
  parameter int unsigned VW           = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  input  logic          cfg_tall,
  input  logic          force_blank,
  output logic          active,
  output logic          vblank,
  output logic          cpu_stall,
  output logic          line_start,
  output logic          frame_start
);
  logic [VW-1:0] height;
  logic          h_pic, v_pic;

  assign height      = cfg_tall ? VW'(TALL_HEIGHT) : VW'(SHORT_HEIGHT);
  assign h_pic       = in_span(32'(hpos), PIC_START, PIC_END);
  assign v_pic       = (vpos != '0) && (vpos <= height);
  assign active      = h_pic && v_pic && !force_blank;
  assign vblank      = vpos > height;
  assign cpu_stall   = in_span(32'(hpos), STALL_START, STALL_START + STALL_LEN);
  assign line_start  = (hpos == '0);
  assign frame_start = line_start && (vpos == '0);

  // Run-length counter used only by the stall checks below.
  localparam int unsigned RW = $clog2(STALL_LEN + 1) + 1;
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)         run_q <= '0;
    else if (cpu_stall) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  p_stall_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> run_q < RW'(STALL_LEN));
  p_stall_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> run_q == RW'(STALL_LEN));
  p_line0_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vpos == '0) |-> !active && !vblank);
  p_vblank_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> !active);
  p_forced_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    force_blank |-> !active);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int unsigned LINE_TICKS   = 1364,
  parameter int unsigned DOT_DIV      = 4,
  parameter int unsigned PIC_START    = 88,
  parameter int unsigned PIC_END      = 1112,
  parameter int unsigned STALL_START  = 536,
  parameter int unsigned STALL_LEN    = 40,
  parameter int unsigned SHORT_HEIGHT = 224,
  parameter int unsigned TALL_HEIGHT  = 239,
  parameter int unsigned LAST_LINE_60 = 261,
  parameter int unsigned LAST_LINE_50 = 311,
  localparam int unsigned HW = $clog2(LINE_TICKS),
  localparam int unsigned VW = $clog2(LAST_LINE_50 + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_50hz,
  input  logic          cfg_tall,
  input  logic          cfg_interlace,
  input  logic          force_blank,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos,
  output logic          dot_en,
  output logic          line_start,
  output logic          active,
  output logic          vblank,
  output logic          cpu_stall,
  output logic          frame_start,
  output logic          even_frame
);
  logic line_end;

  rtg_hcount #(.LINE_TICKS(LINE_TICKS), .DOT_DIV(DOT_DIV), .HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .line_end(line_end), .dot_en(dot_en)
  );

  rtg_vcount #(.LAST_LINE_60(LAST_LINE_60), .LAST_LINE_50(LAST_LINE_50), .VW(VW)) u_v (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .cfg_50hz(cfg_50hz),
    .cfg_interlace(cfg_interlace), .vpos(vpos), .even_frame(even_frame)
  );

  rtg_window #(
    .PIC_START(PIC_START), .PIC_END(PIC_END), .STALL_START(STALL_START),
    .STALL_LEN(STALL_LEN), .SHORT_HEIGHT(SHORT_HEIGHT), .TALL_HEIGHT(TALL_HEIGHT),
    .HW(HW), .VW(VW)
  ) u_w (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .cfg_tall(cfg_tall),
    .force_blank(force_blank), .active(active), .vblank(vblank),
    .cpu_stall(cpu_stall), .line_start(line_start), .frame_start(frame_start)
  );

  p_frame_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start && dot_en && !vblank);
endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam int CLK_PERIOD = 10;
  // Shortened line so whole frames fit in the run; vertical timing stays default.
  localparam int T_LINE = 40, T_DIV = 4, T_PS = 8, T_PE = 32, T_SS = 16, T_SL = 4;
  localparam int HWB = $clog2(T_LINE);
  localparam int VWB = $clog2(311 + 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_50hz = 1'b0, cfg_tall = 1'b0, cfg_interlace = 1'b0, force_blank = 1'b0;
  logic [HWB-1:0] hpos;
  logic [VWB-1:0] vpos;
  logic dot_en, line_start, active, vblank, cpu_stall, frame_start, even_frame;

  int errors = 0, checks = 0;
  int mh = 0, mv = 0;
  bit me = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen #(
    .LINE_TICKS(T_LINE), .DOT_DIV(T_DIV), .PIC_START(T_PS), .PIC_END(T_PE),
    .STALL_START(T_SS), .STALL_LEN(T_SL)
  ) i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_50hz(cfg_50hz), .cfg_tall(cfg_tall),
    .cfg_interlace(cfg_interlace), .force_blank(force_blank), .hpos(hpos),
    .vpos(vpos), .dot_en(dot_en), .line_start(line_start), .active(active),
    .vblank(vblank), .cpu_stall(cpu_stall), .frame_start(frame_start),
    .even_frame(even_frame)
  );

  function automatic int height_of(bit tall);
    return tall ? 239 : 224;
  endfunction
  function automatic int wrap_of(bit pal, bit il, bit even);
    return (pal ? 311 : 261) + ((il && even) ? 1 : 0);
  endfunction
  function automatic bit exp_active(int h, int v, bit tall, bit fb);
    return (h >= T_PS) && (h < T_PE) && (v >= 1) && (v <= height_of(tall)) && !fb;
  endfunction

  // Reference model, advanced on the same edge as the design.
  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; me = 1'b1;
    end else if (mh == T_LINE - 1) begin
      mh = 0;
      if (mv >= wrap_of(cfg_50hz, cfg_interlace, me)) begin
        mv = 0; me = ~me;
      end else mv = mv + 1;
    end else mh = mh + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (h=%0d v=%0d)", req, act, exp, mh, mv);
    end
  endtask

  task automatic check_all();
    chk(int'(hpos) == mh, "R1 hpos", int'(hpos), mh);
    chk(line_start == (mh == 0), "R1 line_start", line_start, mh == 0);
    chk(dot_en == (mh % T_DIV == 0), "R2 dot_en", dot_en, mh % T_DIV == 0);
    chk(cpu_stall == (mh >= T_SS && mh < T_SS + T_SL), "R3 cpu_stall", cpu_stall,
        mh >= T_SS && mh < T_SS + T_SL);
    chk(active == exp_active(mh, mv, cfg_tall, force_blank), "R4 active", active,
        exp_active(mh, mv, cfg_tall, force_blank));
    chk(vblank == (mv > height_of(cfg_tall)), "R5 vblank", vblank,
        mv > height_of(cfg_tall));
    chk(int'(vpos) == mv, "R6 R7 vpos", int'(vpos), mv);
    chk(even_frame == me, "R8 even_frame", even_frame, me);
    chk(frame_start == (mh == 0 && mv == 0), "R9 frame_start", frame_start,
        mh == 0 && mv == 0);
    if (force_blank)
      chk(int'(hpos) == mh && int'(vpos) == mv, "R10 counters under blank",
          int'(vpos), mv);
  endtask

  initial begin
    int frames = 0;
    int tmp;
    int last_v;
    tmp = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(hpos == '0 && vpos == '0, "R8 reset counters", int'(vpos), 0);
    chk(even_frame == 1'b1, "R8 reset parity", even_frame, 1);
    rst_n = 1'b1;
    last_v = 0;
    while (frames < 8) begin
      @(negedge clk);
      check_all();
      // R7/R6: a frame wrap must land on the expected last line.
      if (mh == 0 && mv == 0) begin
        frames++;
        case (frames)
          1: begin cfg_50hz = 0; cfg_tall = 1; cfg_interlace = 0; end
          2: begin cfg_50hz = 1; cfg_tall = 0; cfg_interlace = 0; end
          3, 4: begin cfg_50hz = 0; cfg_tall = 0; cfg_interlace = 1; end
          5, 6: begin cfg_50hz = 1; cfg_tall = 1; cfg_interlace = 1; end
          default: begin
            cfg_50hz = $urandom % 2; cfg_tall = $urandom % 2;
            cfg_interlace = $urandom % 2;
          end
        endcase
      end
      if (mh == 0) force_blank = ($urandom % 4 == 0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Directed frame-length check: R6 and R7 observed via the line before each wrap.
  int prev_v = 0;
  bit prev_pal = 0, prev_il = 0, prev_even = 1;
  always @(negedge clk) begin
    if (rst_n && !done && frame_start && prev_v != 0)
      chk(prev_v == wrap_of(prev_pal, prev_il, prev_even), "R6 R7 last line",
          prev_v, wrap_of(prev_pal, prev_il, prev_even));
    if (rst_n && line_start === 1'b0 && int'(hpos) == T_LINE - 1) begin
      prev_v = int'(vpos); prev_pal = cfg_50hz; prev_il = cfg_interlace;
      prev_even = even_frame;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule